// File: doc/BRIEF.md
# Sparse Record-Table Memory

This block looks, from outside, like a memory with a wide address space: one write port, one read port with a registered output, and a data bus. Inside there is no array as deep as the address space. It holds a small table of address/value records, and storage grows only with the number of distinct addresses touched since reset. Every access first compares its address against all valid records. A hit reads or updates the matching record. A miss claims the lowest free record. When a read misses, the new record is filled from the `rd_init` input, and that same value is returned. A later read of the address therefore returns the same value, whatever `rd_init` holds at that time.

A two-bit reduction select keeps only the low part of the data word and forces the upper bits to zero. This under-approximates the data width of a modelled storage resource. The mask applies to written data, to fill values and to the read output. When a miss finds no free record, the table is left as it was and `overflow` pulses for one cycle.

Top module: `sparse_access_mem`

## Requirements
- R1: Synchronous active-high reset invalidates every record and clears `rd_data` and `overflow` to zero. After reset, any read is a miss.
- R2: A read returns its value on `rd_data` in the cycle after `rd_en` is sampled. A read of an address that was written returns the written value.
- R3: A write to an address that already has a record overwrites that record and uses no new one. At most one record ever matches an address.
- R4: A read miss returns the masked `rd_init` value and stores it as a new record. Later reads of that address return the stored value, even if `rd_init` has changed.
- R5: When a read and a write target the same address in one cycle, the read returns the value held before that cycle (the fill value if no record existed). The table then holds the written value, in a single record.
- R6: While `rd_en` is low, `rd_data` holds its previous value.
- R7: A miss when no record is free leaves every record unchanged. This holds for the failed address and for all existing records. `overflow` is high in the following cycle. Records are never removed except by reset.
- R8: When a write miss and a read miss to different addresses fall in the same cycle, the write claims a free record first and the read takes the next one. If only one record is free, the write is stored, the read still returns its fill value, and `overflow` rises.
- R9: `red_sel` encodes the kept width. 0 keeps all bits, 1 keeps the low half, 2 keeps the low quarter and 3 keeps the low eighth of the data bits. The other bits are zero in stored write data, in stored fill values and on `rd_data`.
- R10: `overflow` is low in every cycle that follows a cycle in which no allocation failed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write enable |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read enable |
| rd_addr | input | ADDR_W | Read address |
| rd_init | input | DATA_W | Value used to fill a record on a read miss |
| red_sel | input | 2 | Data-width reduction select |
| rd_data | output | DATA_W | Registered read data |
| overflow | output | 1 | One-cycle pulse after an allocation found no free record |

## Verification
A read and a write can fall in the same cycle in two ways. They can share one address, where the read must see the old contents. They can be two misses to different addresses, which contend for free records. The bench provokes the first case with the address already present and then absent. It judges the result by the returned value and by a follow-up read of the stored one. It provokes the second case with exactly one record left. It judges that case by the overflow pulse, the fill value returned, and a follow-up read proving the write was kept.

// File: rtl/sparse_mem_pkg.sv
package sparse_mem_pkg;

    // Data-width reduction: number of low data bits that survive.
    typedef enum logic [1:0] {
        RED_FULL    = 2'd0,
        RED_HALF    = 2'd1,
        RED_QUARTER = 2'd2,
        RED_EIGHTH  = 2'd3
    } red_mode_e;

    function automatic int unsigned kept_bits(input int unsigned width,
                                              input red_mode_e mode);
        return width >> int'(mode);
    endfunction

    function automatic int unsigned idx_width(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/sparse_mem_reduce.sv
module sparse_mem_reduce
    import sparse_mem_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  red_mode_e         mode,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    int unsigned keep;
    assign keep = kept_bits(DATA_W, mode);

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        assign dout[b] = din[b] & (b < keep);
    end
endmodule

// File: rtl/sparse_mem_match.sv
module sparse_mem_match #(
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned IDX_W   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ENTRIES-1:0] valid,
    input  logic [ADDR_W-1:0] tags [ENTRIES],
    input  logic [ADDR_W-1:0] key,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);
    logic [ENTRIES-1:0] hit_vec;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        assign hit_vec[e] = valid[e] && (tags[e] == key);
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < int'(ENTRIES); i++) begin
            if (hit_vec[i]) idx = IDX_W'(i);
        end
    end

    assign hit = |hit_vec;

    AST_SINGLE_RECORD: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec)); // R3
endmodule

// File: rtl/sparse_mem_pick.sv
module sparse_mem_pick #(
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned IDX_W   = 3
) (
    input  logic [ENTRIES-1:0] free,
    output logic               found,
    output logic [IDX_W-1:0]   idx
);
    // Lowest free index wins.
    always_comb begin
        idx = '0;
        for (int i = int'(ENTRIES) - 1; i >= 0; i--) begin
            if (free[i]) idx = IDX_W'(i);
        end
    end
    assign found = |free;
endmodule

// File: rtl/sparse_access_mem.sv
module sparse_access_mem
    import sparse_mem_pkg::*;
#(
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned ENTRIES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_init,
    input  logic [1:0]        red_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic              overflow
);
    localparam int unsigned IDX_W = idx_width(ENTRIES);

    typedef struct packed {
        logic [ADDR_W-1:0] tag;
        logic [DATA_W-1:0] val;
    } rec_t;

    rec_t               rec   [ENTRIES];
    logic [ADDR_W-1:0]  tags  [ENTRIES];
    logic [ENTRIES-1:0] valid;

    red_mode_e mode;
    assign mode = red_mode_e'(red_sel);

    for (genvar e = 0; e < ENTRIES; e++) begin : g_tag
        assign tags[e] = rec[e].tag;
    end

    // Masked data paths
    logic [DATA_W-1:0] wr_m, init_m, rd_raw, rd_m;

    sparse_mem_reduce #(.DATA_W(DATA_W)) u_red_wr   (.mode(mode), .din(wr_data), .dout(wr_m));
    sparse_mem_reduce #(.DATA_W(DATA_W)) u_red_init (.mode(mode), .din(rd_init), .dout(init_m));
    sparse_mem_reduce #(.DATA_W(DATA_W)) u_red_rd   (.mode(mode), .din(rd_raw),  .dout(rd_m));

    // Lookups
    logic             wr_hit, rd_hit;
    logic [IDX_W-1:0] wr_idx, rd_idx;

    sparse_mem_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_match_wr (
        .clk(clk), .rst(rst), .valid(valid), .tags(tags), .key(wr_addr),
        .hit(wr_hit), .idx(wr_idx));
    sparse_mem_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_match_rd (
        .clk(clk), .rst(rst), .valid(valid), .tags(tags), .key(rd_addr),
        .hit(rd_hit), .idx(rd_idx));

    // Free-slot selection: first for the write, second for the read
    logic [ENTRIES-1:0] free1, free2;
    logic               f1_ok, f2_ok;
    logic [IDX_W-1:0]   f1, f2;

    assign free1 = ~valid;
    assign free2 = f1_ok ? (free1 & ~(ENTRIES'(1) << f1)) : free1;

    sparse_mem_pick #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_pick1 (.free(free1), .found(f1_ok), .idx(f1));
    sparse_mem_pick #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_pick2 (.free(free2), .found(f2_ok), .idx(f2));

    logic             same_addr, wr_alloc, rd_alloc, rd_slot_ok, alloc_fail;
    logic [IDX_W-1:0] rd_slot;

    assign same_addr  = wr_en && rd_en && (wr_addr == rd_addr);
    assign wr_alloc   = wr_en && !wr_hit;
    assign rd_alloc   = rd_en && !rd_hit && !same_addr;
    assign rd_slot_ok = wr_alloc ? f2_ok : f1_ok;
    assign rd_slot    = wr_alloc ? f2 : f1;
    assign alloc_fail = (wr_alloc && !f1_ok) || (rd_alloc && !rd_slot_ok);

    // Read value reflects the table before this cycle's write
    assign rd_raw = rd_hit ? rec[rd_idx].val : init_m;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid    <= '0;
            rd_data  <= '0;
            overflow <= 1'b0;
        end else begin
            overflow <= alloc_fail;
            if (rd_en) rd_data <= rd_m;
            for (int i = 0; i < int'(ENTRIES); i++) begin
                if ((wr_alloc && f1_ok && f1 == IDX_W'(i)) ||
                    (rd_alloc && rd_slot_ok && rd_slot == IDX_W'(i)))
                    valid[i] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < int'(ENTRIES); i++) begin
            if (wr_en && wr_hit && wr_idx == IDX_W'(i))
                rec[i].val <= wr_m;
            else if (wr_alloc && f1_ok && f1 == IDX_W'(i))
                rec[i] <= '{tag: wr_addr, val: wr_m};
            else if (rd_alloc && rd_slot_ok && rd_slot == IDX_W'(i))
                rec[i] <= '{tag: rd_addr, val: init_m};
        end
    end

    AST_OVF_FULL: assert property (@(posedge clk) disable iff (rst)
        overflow |-> (&valid)); // R7
    AST_NO_EVICT: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((valid & $past(valid)) == $past(valid))); // R7
    AST_Q_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data)); // R6
    AST_Q_MASKED: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> ((rd_data >> kept_bits(DATA_W, $past(mode))) == '0)); // R9
endmodule

// File: tb/test_sparse_access_mem.sv
module test_sparse_access_mem;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [15:0] wr_addr = '0, wr_data = '0, rd_addr = '0, rd_init = '0;
    logic [1:0]  red_sel = '0;
    logic [15:0] rd_data;
    logic        overflow;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk; // 50 MHz

    sparse_access_mem #(.ADDR_W(16), .DATA_W(16), .ENTRIES(8)) i_sparse_access_mem (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_init(rd_init), .red_sel(red_sel),
        .rd_data(rd_data), .overflow(overflow));

    typedef struct packed {
        logic        we;
        logic [15:0] wa;
        logic [15:0] d;
        logic        re;
        logic [15:0] ra;
        logic [15:0] init;
        logic [1:0]  sel;
        logic [15:0] exp_q;
        logic        exp_ovf;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 16'h0010, 16'h1234, 1'b0, 16'h0000, 16'h0000, 2'd0, 16'h0000, 1'b0, 8'd6}, // R6 no read
        '{1'b0, 16'h0000, 16'h0000, 1'b1, 16'h0010, 16'h0000, 2'd0, 16'h1234, 1'b0, 8'd2}, // R2
        '{1'b1, 16'h0010, 16'hBEEF, 1'b0, 16'h0000, 16'h0000, 2'd0, 16'h1234, 1'b0, 8'd3}, // R3
        '{1'b0, 16'h0000, 16'h0000, 1'b1, 16'h0010, 16'h0000, 2'd0, 16'hBEEF, 1'b0, 8'd3}, // R3
        '{1'b0, 16'h0000, 16'h0000, 1'b1, 16'h0020, 16'h5A5A, 2'd0, 16'h5A5A, 1'b0, 8'd4}, // R4 miss
        '{1'b0, 16'h0000, 16'h0000, 1'b1, 16'h0020, 16'h0000, 2'd0, 16'h5A5A, 1'b0, 8'd4}, // R4 kept
        '{1'b1, 16'h0020, 16'h7777, 1'b1, 16'h0020, 16'h0000, 2'd0, 16'h5A5A, 1'b0, 8'd5}, // R5 hit
        '{1'b0, 16'h0000, 16'h0000, 1'b1, 16'h0020, 16'h0000, 2'd0, 16'h7777, 1'b0, 8'd5}, // R5
        '{1'b1, 16'h0030, 16'h1111, 1'b1, 16'h0030, 16'h2222, 2'd0, 16'h2222, 1'b0, 8'd5}, // R5 miss
        '{1'b0, 16'h0000, 16'h0000, 1'b1, 16'h0030, 16'h0000, 2'd0, 16'h1111, 1'b0, 8'd5}, // R5
        '{1'b0, 16'h0000, 16'h0000, 1'b0, 16'h0000, 16'h0000, 2'd0, 16'h1111, 1'b0, 8'd6}  // R6 idle
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic we, input logic [15:0] wa, input logic [15:0] d,
                        input logic re, input logic [15:0] ra, input logic [15:0] init,
                        input logic [1:0] sel);
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = d;
        rd_en = re; rd_addr = ra; rd_init = init; red_sel = sel;
        @(posedge clk);
        #2;
    endtask

    task automatic expect_out(input string tag, input logic [15:0] q, input logic ovf);
        check({tag, " rd_data"}, rd_data, q);
        check({tag, " overflow"}, {15'd0, overflow}, {15'd0, ovf});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        wr_en = 1'b0; rd_en = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        expect_out("R1 reset", 16'h0000, 1'b0);

        for (int i = 0; i < NV; i++) begin
            step(VECS[i].we, VECS[i].wa, VECS[i].d, VECS[i].re, VECS[i].ra,
                 VECS[i].init, VECS[i].sel);
            expect_out($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].exp_q, VECS[i].exp_ovf);
        end

        // R9 reduction modes (records 0x40, 0x50, 0x60 allocated)
        step(1'b1, 16'h0040, 16'hABCD, 1'b0, 16'h0, 16'h0, 2'd1);
        step(1'b0, 16'h0, 16'h0, 1'b1, 16'h0040, 16'h0, 2'd1);
        expect_out("R9 half", 16'h00CD, 1'b0);
        step(1'b0, 16'h0, 16'h0, 1'b1, 16'h0050, 16'hFFFF, 2'd2);
        expect_out("R9 quarter", 16'h000F, 1'b0);
        step(1'b0, 16'h0, 16'h0, 1'b1, 16'h0060, 16'hFFFF, 2'd3);
        expect_out("R9 eighth", 16'h0003, 1'b0);
        step(1'b0, 16'h0, 16'h0, 1'b1, 16'h0040, 16'h0, 2'd0);
        expect_out("R9 stored masked", 16'h00CD, 1'b0);

        // Seventh record, then R8 contention with one record left
        step(1'b1, 16'h0070, 16'h0707, 1'b0, 16'h0, 16'h0, 2'd0);
        expect_out("R7 fill", 16'h00CD, 1'b0);
        step(1'b1, 16'h0080, 16'h0808, 1'b1, 16'h0090, 16'h0909, 2'd0);
        expect_out("R8 dual miss", 16'h0909, 1'b1);
        step(1'b0, 16'h0, 16'h0, 1'b1, 16'h0080, 16'h0, 2'd0);
        expect_out("R8 R10 write kept", 16'h0808, 1'b0);

        // R7 full table
        step(1'b0, 16'h0, 16'h0, 1'b1, 16'h0090, 16'h1234, 2'd0);
        expect_out("R7 read miss full", 16'h1234, 1'b1);
        step(1'b1, 16'h00A0, 16'h5555, 1'b0, 16'h0, 16'h0, 2'd0);
        expect_out("R7 write miss full", 16'h1234, 1'b1);
        step(1'b0, 16'h0, 16'h0, 1'b1, 16'h00A0, 16'h0000, 2'd0);
        expect_out("R7 not stored", 16'h0000, 1'b1);
        step(1'b0, 16'h0, 16'h0, 1'b1, 16'h0010, 16'h0000, 2'd0);
        expect_out("R7 R10 old record", 16'hBEEF, 1'b0);
        step(1'b1, 16'h0010, 16'h4444, 1'b0, 16'h0, 16'h0, 2'd0);
        expect_out("R3 hit when full", 16'hBEEF, 1'b0);
        step(1'b0, 16'h0, 16'h0, 1'b1, 16'h0010, 16'h0, 2'd0);
        expect_out("R3 overwrite", 16'h4444, 1'b0);

        // R1 reset clears records
        do_reset();
        expect_out("R1 reset again", 16'h0000, 1'b0);
        step(1'b0, 16'h0, 16'h0, 1'b1, 16'h0010, 16'h0000, 2'd0);
        expect_out("R1 cleared", 16'h0000, 1'b0);
        step(1'b0, 16'h0, 16'h0, 1'b1, 16'h0020, 16'h0ABC, 2'd0);
        expect_out("R1 R4 fresh miss", 16'h0ABC, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule